// File: doc/BRIEF.md
# Encoder Velocity Capture Unit

This block measures how fast a shaft encoder turns by counting velocity pulses over fixed time windows. A down-counting period timer, reloaded from a programmable value, marks out each window. While a window is open, a running counter adds up the pulses. When the timer runs out, the final total, including a pulse that arrives in that same cycle, moves into a speed register, and the running counter starts again from zero. A single velocity enable bit freezes the timer, the running counter and the speed register together, so the running count is kept across a pause.

Quadrature decoding happens upstream. The unit receives single-cycle strobes for a velocity pulse, an index pulse, a direction change and a phase error. Window expiry, index, direction change and phase error each set a sticky raw status bit. Software clears a bit by writing a one to it. An enable mask picks which raw bits drive the single interrupt line. All state can be reached through a simple word-addressed port: writes are sampled on the clock, and read data follows the address combinationally.

Top module: `enc_vel_capture`

## Requirements
- R1: After reset, the control bit, running count, speed, interrupt enables and raw status read 0, `irq` is 0, and both the load value (address 1) and the timer (address 2) read the `LOAD_RST` parameter.
- R2: While velocity enable (address 0, bit 0) is 1, each non-expiry cycle with `vel_pulse` high adds one to the running count at address 3. The new value can be read in the following cycle.
- R3: While enabled, the timer at address 2 drops by one each cycle. In an enabled cycle where it is already 0, it reloads the load value at address 1 (read/write, `TMR_W` bits). Each window therefore lasts load+1 enabled cycles.
- R4: In the expiry cycle, the speed register at address 4 takes the running count plus that cycle's `vel_pulse`, and the running count becomes 0. Speed changes at no other time.
- R5: While velocity enable is 0, the running count, timer and speed hold their values and no expiry event occurs. When the enable is set again, counting resumes from the held values.
- R6: Raw status at address 6 has bit 0 for index, bit 1 for timer expiry, bit 2 for direction change and bit 3 for phase error, and reads 0 in bits 31:4. An event sets its bit in the following cycle. The bit stays at 1 whatever the enable mask holds.
- R7: Writing to address 7 clears each raw status bit whose data bit is 1 and leaves the other bits unchanged. If an event arrives in the same cycle as the clear, the bit stays set. Address 7 reads 0.
- R8: `irq` is 1 exactly when some raw status bit and the same bit of the enable mask are both 1. The enable mask sits at address 5 bits 3:0, and bits 31:4 of that address read 0. `irq` follows a change in either one cycle after the change is sampled.
- R9: Writes to addresses 2, 3, 4 and 6 have no effect, and addresses 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Word address for reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| vel_pulse | input | 1 | Velocity pulse strobe |
| dir_chg | input | 1 | Direction change strobe |
| index_pulse | input | 1 | Index pulse strobe |
| phase_err | input | 1 | Phase error strobe |
| irq | output | 1 | Interrupt, raw status masked by enables |

## Verification
Every stored value changes on the rising edge that samples the stimulus or the write. Because read data is combinational, a result is due in the cycle right after its cause, and this holds for the count, the timer, the status bits and `irq` alike. Speed is due one cycle after the enabled cycle in which the timer reads 0, so a window spans load+1 enabled cycles. The bench drives each cycle's inputs on the falling edge and advances its own model on the rising edge. It compares the design output against the model two nanoseconds after the next falling edge, so each check looks at exactly the cycle in which the result is due.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // number of latched event sources
  localparam int unsigned NUM_EV = 4;

  // raw status bit positions
  localparam int unsigned EV_INDEX = 0;
  localparam int unsigned EV_TIMER = 1;
  localparam int unsigned EV_DIR   = 2;
  localparam int unsigned EV_PERR  = 3;

  // register word addresses
  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_LOAD  = 4'd1,
    A_TIMER = 4'd2,
    A_COUNT = 4'd3,
    A_SPEED = 4'd4,
    A_IEN   = 4'd5,
    A_RAW   = 4'd6,
    A_ICLR  = 4'd7
  } evc_reg_e;

  // one sticky status bit: a set in the same cycle beats a clear
  function automatic logic f_latch_bit(input logic q, input logic set, input logic clr);
    return (q & ~clr) | set;
  endfunction

  // interrupt from raw status and enable mask
  function automatic logic f_irq(input logic [NUM_EV-1:0] raw, input logic [NUM_EV-1:0] ien);
    return |(raw & ien);
  endfunction

endpackage

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LOAD_RST = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TMR_W-1:0]  tmr_val,
  input  logic [CNT_W-1:0]  run_cnt,
  input  logic [CNT_W-1:0]  speed,
  input  logic [NUM_EV-1:0] raw,
  output logic              vel_en,
  output logic [TMR_W-1:0]  load_val,
  output logic [NUM_EV-1:0] ien,
  output logic [NUM_EV-1:0] clr_mask,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned HI_W = DATA_W - TMR_W;

  logic              en_q;
  logic [TMR_W-1:0]  load_q;
  logic [NUM_EV-1:0] ien_q;
  logic              hit_ctrl;
  logic              hit_load;
  logic              hit_ien;
  logic              hit_iclr;

  assign hit_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
  assign hit_load = wr_en && (addr == ADDR_W'(A_LOAD));
  assign hit_ien  = wr_en && (addr == ADDR_W'(A_IEN));
  assign hit_iclr = wr_en && (addr == ADDR_W'(A_ICLR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      load_q <= TMR_W'(LOAD_RST);
      ien_q  <= '0;
    end else begin
      if (hit_ctrl) en_q   <= wr_data[0];
      if (hit_load) load_q <= wr_data[TMR_W-1:0];
      if (hit_ien)  ien_q  <= wr_data[NUM_EV-1:0];
    end
  end

  assign vel_en   = en_q;
  assign load_val = load_q;
  assign ien      = ien_q;
  assign clr_mask = hit_iclr ? wr_data[NUM_EV-1:0] : '0;

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_W'(A_CTRL):  rd_data = DATA_W'(en_q);
      ADDR_W'(A_LOAD):  rd_data = DATA_W'(load_q);
      ADDR_W'(A_TIMER): rd_data = DATA_W'(tmr_val);
      ADDR_W'(A_COUNT): rd_data = DATA_W'(run_cnt);
      ADDR_W'(A_SPEED): rd_data = DATA_W'(speed);
      ADDR_W'(A_IEN):   rd_data = DATA_W'(ien_q);
      ADDR_W'(A_RAW):   rd_data = DATA_W'(raw);
      default:          rd_data = '0;
    endcase
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[DATA_W-1:TMR_W];
    end
  endgenerate

  // R3: a write to the load address is what the timer reloads from next
  a_r3_load_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_load |=> load_val == $past(wr_data[TMR_W-1:0]));

  // R8: the enable mask moves only on a write to its address
  a_r8_ien_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ien |=> $stable(ien));

endmodule

// File: rtl/evc_period_timer.sv
module evc_period_timer #(
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned LOAD_RST = 99
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] tmr_val,
  output logic             expire
);

  logic [TMR_W-1:0] tmr_q;

  function automatic logic [TMR_W-1:0] f_tmr_next(input logic [TMR_W-1:0] cur,
                                                   input logic [TMR_W-1:0] rl,
                                                   input logic             hit);
    return hit ? rl : cur - TMR_W'(1);
  endfunction

  assign expire  = run && (tmr_q == '0);
  assign tmr_val = tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   tmr_q <= TMR_W'(LOAD_RST);
    else if (run) tmr_q <= f_tmr_next(tmr_q, load_val, expire);
  end

  // R3: steps down by one while running
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tmr_q != '0) |=> tmr_q == $past(tmr_q) - TMR_W'(1));

  // R3: reloads on expiry
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmr_q == $past(load_val));

  // R5: frozen while stopped
  a_r5_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(tmr_q));

endmodule

// File: rtl/evc_pulse_window.sv
module evc_pulse_window #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pulse,
  input  logic             close,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] speed
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] spd_q;

  function automatic logic [CNT_W-1:0] f_total(input logic [CNT_W-1:0] cnt, input logic p);
    return cnt + CNT_W'(p);
  endfunction

  function automatic logic [CNT_W-1:0] f_after(input logic [CNT_W-1:0] cnt, input logic p,
                                               input logic cl);
    return cl ? '0 : f_total(cnt, p);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      spd_q <= '0;
    end else if (run) begin
      cnt_q <= f_after(cnt_q, pulse, close);
      if (close) spd_q <= f_total(cnt_q, pulse);
    end
  end

  assign run_cnt = cnt_q;
  assign speed   = spd_q;

  // R2: adds the pulse while the window is open
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !close) |=> cnt_q == $past(cnt_q) + CNT_W'($past(pulse)));

  // R4: capture includes the closing cycle's pulse, count restarts
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (spd_q == $past(cnt_q) + CNT_W'($past(pulse))) && (cnt_q == '0));

  // R4: speed changes only at a window close
  a_r4_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !close |=> $stable(spd_q));

  // R5: running count frozen while stopped
  a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

endmodule

// File: rtl/evc_event_latch.sv
module evc_event_latch
  import evc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic [NUM_EV-1:0] clr,
  input  logic [NUM_EV-1:0] ien,
  output logic [NUM_EV-1:0] raw,
  output logic              irq
);

  logic [NUM_EV-1:0] raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      for (int i = 0; i < NUM_EV; i++) begin
        raw_q[i] <= f_latch_bit(raw_q[i], ev[i], clr[i]);
      end
    end
  end

  assign raw = raw_q;
  assign irq = f_irq(raw_q, ien);

  generate
    for (genvar g = 0; g < NUM_EV; g++) begin : g_src
      // R6: a set bit stays set unless cleared
      a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[g] && !clr[g]) |=> raw_q[g]);

      // R7: an event wins over a clear in the same cycle
      a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev[g] |=> raw_q[g]);

      // R7: a clear without an event empties the bit
      a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[g] && !ev[g]) |=> !raw_q[g]);
    end
  endgenerate

endmodule

// File: rtl/enc_vel_capture.sv
module enc_vel_capture
  import evc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LOAD_RST = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              vel_pulse,
  input  logic              dir_chg,
  input  logic              index_pulse,
  input  logic              phase_err,
  output logic              irq
);

  logic              vel_en;
  logic [TMR_W-1:0]  load_val;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_expire;
  logic [CNT_W-1:0]  run_cnt;
  logic [CNT_W-1:0]  speed;
  logic [NUM_EV-1:0] ien;
  logic [NUM_EV-1:0] clr_mask;
  logic [NUM_EV-1:0] raw;
  logic [NUM_EV-1:0] ev_vec;

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_INDEX] = index_pulse;
    ev_vec[EV_TIMER] = tmr_expire;
    ev_vec[EV_DIR]   = dir_chg;
    ev_vec[EV_PERR]  = phase_err;
  end

  evc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMR_W(TMR_W), .CNT_W(CNT_W), .LOAD_RST(LOAD_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .tmr_val(tmr_val), .run_cnt(run_cnt), .speed(speed), .raw(raw),
    .vel_en(vel_en), .load_val(load_val), .ien(ien), .clr_mask(clr_mask),
    .rd_data(rd_data)
  );

  evc_period_timer #(.TMR_W(TMR_W), .LOAD_RST(LOAD_RST)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(vel_en), .load_val(load_val),
    .tmr_val(tmr_val), .expire(tmr_expire)
  );

  evc_pulse_window #(.CNT_W(CNT_W)) u_window (
    .clk(clk), .rst_n(rst_n), .run(vel_en), .pulse(vel_pulse), .close(tmr_expire),
    .run_cnt(run_cnt), .speed(speed)
  );

  evc_event_latch u_events (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr_mask), .ien(ien),
    .raw(raw), .irq(irq)
  );

  // R6: a window close always leaves the timer status bit set
  a_r6_timer_event: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> raw[EV_TIMER]);

endmodule

// File: tb/test_enc_vel_capture.sv
module test_enc_vel_capture;
  import evc_pkg::*;

  localparam int DW   = 32;
  localparam int AW   = 4;
  localparam int TW   = 16;
  localparam int LRST = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          vel_pulse = 1'b0, dir_chg = 1'b0, index_pulse = 1'b0, phase_err = 1'b0;
  wire  [DW-1:0] rd_data;
  wire           irq;

  enc_vel_capture #(.LOAD_RST(LRST)) i_enc_vel_capture (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .vel_pulse(vel_pulse), .dir_chg(dir_chg),
    .index_pulse(index_pulse), .phase_err(phase_err), .irq(irq)
  );

  // reference model built from the requirements
  logic          m_en;
  logic [TW-1:0] m_load, m_tmr;
  logic [31:0]   m_cnt, m_speed;
  logic [3:0]    m_raw, m_ien;

  always @(posedge clk) begin : model
    logic       m_exp;
    logic [3:0] m_ev, m_clr;
    if (!rst_n) begin
      m_en = 1'b0; m_load = LRST; m_tmr = LRST;
      m_cnt = '0; m_speed = '0; m_raw = '0; m_ien = '0;
    end else begin
      m_exp = m_en && (m_tmr == 0);
      m_ev  = {phase_err, dir_chg, m_exp, index_pulse};
      m_clr = (wr_en && addr == 4'd7) ? wr_data[3:0] : 4'd0;
      if (m_en) begin
        if (m_exp) begin
          m_speed = m_cnt + {31'b0, vel_pulse};
          m_cnt   = '0;
          m_tmr   = m_load;
        end else begin
          m_cnt = m_cnt + {31'b0, vel_pulse};
          m_tmr = m_tmr - 1'b1;
        end
      end
      m_raw = (m_raw & ~m_clr) | m_ev;
      if (wr_en && addr == 4'd0) m_en   = wr_data[0];
      if (wr_en && addr == 4'd1) m_load = wr_data[TW-1:0];
      if (wr_en && addr == 4'd5) m_ien  = wr_data[3:0];
    end
  end

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      4'd0: return {31'b0, m_en};
      4'd1: return {16'b0, m_load};
      4'd2: return {16'b0, m_tmr};
      4'd3: return m_cnt;
      4'd4: return m_speed;
      4'd5: return {28'b0, m_ien};
      4'd6: return {28'b0, m_raw};
      default: return '0;
    endcase
  endfunction

  // scoreboard
  typedef struct {
    bit            is_irq;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sbq[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic p, input logic dc, input logic ix, input logic pe);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d;
    vel_pulse = p; dir_chg = dc; index_pulse = ix; phase_err = pe;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic p);
    step(1'b0, '0, '0, p, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic check_rd(input logic [AW-1:0] a, input string tag);
    item_t it;
    step(1'b0, a, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    it.is_irq = 1'b0; it.exp = model_read(a); it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic check_lit(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    step(1'b0, a, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic check_irq(input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, |(m_raw & m_ien)}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        logic [DW-1:0] act;
        it = sbq.pop_front();
        act = it.is_irq ? {31'b0, irq} : rd_data;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_lit(A_CTRL,  0,    "R1 ctrl");
    check_lit(A_LOAD,  LRST, "R1 load");
    check_lit(A_TIMER, LRST, "R1 timer");
    check_lit(A_COUNT, 0,    "R1 count");
    check_lit(A_SPEED, 0,    "R1 speed");
    check_lit(A_IEN,   0,    "R1 enables");
    check_lit(A_RAW,   0,    "R1 raw");
    check_irq("R1 irq");
    check_lit(4'd9, 0, "R9 unmapped read");

    // R5 disabled: pulses ignored
    repeat (4) idle(1'b1);
    check_lit(A_COUNT, 0,    "R5 count held while off");
    check_lit(A_TIMER, LRST, "R5 timer held while off");

    // R3 load value, then continuous pulses
    wr(A_LOAD, 3);
    check_lit(A_LOAD, 3, "R3 load read back");
    wr(A_CTRL, 1);
    repeat (30) idle(1'b1);
    check_lit(A_SPEED, 4, "R4 window of load+1 includes expiry pulse");
    check_rd(A_COUNT, "R2 running count");
    check_rd(A_TIMER, "R3 timer");

    // R2/R3/R4 mixed pulse pattern
    for (int i = 0; i < 48; i++) begin
      idle(i % 3 != 1);
      if (i % 6 == 5) check_rd(A_COUNT, "R2 running count");
      if (i % 8 == 7) check_rd(A_SPEED, "R4 captured speed");
      if (i % 7 == 3) check_rd(A_TIMER, "R3 timer");
    end

    // R8 timer expiry drives irq when enabled
    wr(A_IEN, 2);
    check_rd(A_RAW, "R6 timer bit1 set");
    check_irq("R8 timer interrupt");

    // R5 disable, R7 clear
    wr(A_CTRL, 0);
    wr(A_ICLR, 2);
    check_rd(A_RAW, "R7 clear timer bit");
    check_irq("R8 irq after clear");
    repeat (20) idle(1'b1);
    check_rd(A_COUNT, "R5 count held");
    check_rd(A_TIMER, "R5 timer held");
    check_rd(A_SPEED, "R5 speed held");
    check_lit(A_RAW, 0, "R5 no expiry while off");

    // R6 event latching
    wr(A_IEN, 0);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_lit(A_RAW, 32'h1, "R6 index bit0");
    check_irq("R8 masked");
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    check_lit(A_RAW, 32'h5, "R6 direction bit2");
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    check_lit(A_RAW, 32'hD, "R6 phase error bit3");
    repeat (3) idle(1'b0);
    check_lit(A_RAW, 32'hD, "R6 sticky");

    // R8 enable mask
    wr(A_IEN, 8);
    check_irq("R8 phase error enabled");
    check_lit(A_RAW, 32'hD, "R8 raw unaffected");
    wr(A_IEN, 32'hFFFF_FFF2);
    check_lit(A_IEN, 32'h2, "R8 upper enable bits read 0");
    check_irq("R8 irq off with bit1 only");

    // R7 clears
    wr(A_ICLR, 8);
    check_lit(A_RAW, 32'h5, "R7 clear bit3 only");
    step(1'b1, A_ICLR, 32'h1, 1'b0, 1'b0, 1'b1, 1'b0);
    check_lit(A_RAW, 32'h5, "R7 event wins over clear");
    wr(A_ICLR, 32'hF);
    check_lit(A_RAW, 0, "R7 clear all");
    check_lit(A_ICLR, 0, "R7 clear address reads 0");

    // R9 writes to read-only addresses
    wr(A_COUNT, 32'h1234);
    wr(A_SPEED, 32'h5678);
    wr(A_TIMER, 32'h9);
    wr(A_RAW, 32'hF);
    check_rd(A_COUNT, "R9 count write ignored");
    check_rd(A_SPEED, "R9 speed write ignored");
    check_rd(A_TIMER, "R9 timer write ignored");
    check_lit(A_RAW, 0, "R9 raw write ignored");

    // R5 resume from held values
    wr(A_CTRL, 1);
    repeat (2) idle(1'b1);
    check_rd(A_COUNT, "R5 resume count");
    for (int i = 0; i < 12; i++) idle(i % 2 == 0);
    check_rd(A_SPEED, "R4 speed after resume");
    check_rd(A_COUNT, "R2 count after resume");
    check_irq("R8 timer interrupt after resume");

    repeat (3) @(negedge clk);
    #3;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule